// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block brings a bank of DDR SDRAM ranks from power-on to normal operation. A pulse on the start input launches a fixed sequence of fifteen commands. Each command is broadcast to every populated rank, and a programmable wait follows it. The wait is counted in delay units, and one unit is a parameterized number of clocks (nominally 200 us). Each command is issued by setting a 3-bit command code and then strobing one address per target rank. For the two mode-register commands, the mode word is folded into the low address bits.

Rank population comes from a table of cumulative end boundaries in 32 MB units. The block walks the table in index order, keeping a running start. A rank whose end lies above the running start is strobed at that start, shifted up by 25 bits, plus the folded mode offset. The running start then advances to that end. The final "normal" step only switches the controller mode and strobes nothing. The block then raises an init-complete flag and stays busy for a trailing wait.

Top module: `ddr_init_sequencer`

## Requirements
- R1: The command output carries these codes: 0 self refresh, 1 NOP, 2 precharge all, 3 mode set, 4 extended mode set, 6 auto refresh, 7 normal. The code is stable while a command's strobes are issued.
- R2: After start, the strobed commands follow this order: NOP, precharge, extended mode set, mode set, precharge, eight auto refreshes, mode set. The normal step (code 7) comes last.
- R3: The waits are as follows. Two units pass between start and the NOP. Three units follow NOP, each precharge, the extended mode set, each auto refresh and the normal step. No wait follows either mode set.
- R4: A mode word's bit 11 is placed on address bit 13, and its bits 9:0 on address bits 12:3. The extended mode set uses word 0x000 (DLL enabled), so its address offset is 0. The first mode set uses word 0x16A (burst length 4, interleaved, CAS 2.5, DLL reset), giving offset 0xB50. The second mode set uses word 0x06A, giving offset 0x350. All other commands use offset 0.
- R5: For each broadcast command, ranks are visited in index order with a running start that begins at 0. Rank i is strobed only if its 8-bit end exceeds the running start. The strobe address is (start << 25) + offset, after which the running start becomes that end.
- R6: The normal step produces no strobe.
- R7: init_done rises at least three units after the last strobe of the sequence. busy then stays high for five more units before falling.
- R8: A start pulse while busy is ignored. A start pulse while idle clears init_done and begins a new sequence.
- R9: After reset: busy 0, init_done 0, strobe 0, command code 1.
- R10: When no rank end exceeds the running start, the sequence runs to completion with no strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin the power-up sequence (accepted only when idle) |
| rank_end_i | input | NUM_RANKS*BOUND_W | Cumulative rank end boundaries, rank 0 in the low byte |
| cmd_code_o | output | 3 | Current controller command code |
| cmd_addr_o | output | BOUND_W+UNIT_SHIFT | Access address for the strobed rank |
| cmd_strobe_o | output | 1 | One-cycle access strobe, one per populated rank |
| init_done_o | output | 1 | Initialization complete flag |
| busy_o | output | 1 | Sequence in progress, including the trailing wait |

## Verification
On every cycle, the assertions check the following. No strobe appears under the normal code or while idle. The command code holds across back-to-back strobes. init_done can only rise under the normal code. Every strobe and timer expiry is preceded by an active walk or an active wait. Only the bench's scenarios can show the rest. These are the full command order, the folded mode offsets, rank selection under monotonic, duplicate, non-monotonic, saturated and empty boundary tables, and the wait lengths measured between strobes. They also cover the ignored mid-run start and the clearing of init_done on restart.

// File: rtl/ddrinit_pkg.sv
package ddrinit_pkg;

  typedef enum logic [2:0] {
    CMD_SELF_REFRESH = 3'd0,
    CMD_NOP          = 3'd1,
    CMD_PRECHARGE    = 3'd2,
    CMD_MODE_SET     = 3'd3,
    CMD_EXT_MODE_SET = 3'd4,
    CMD_AUTO_REFRESH = 3'd6,
    CMD_NORMAL       = 3'd7
  } cmd_e;

  localparam int NUM_STEPS  = 15;
  localparam int STEP_W     = 4;
  localparam int UNITS_W    = 3;
  localparam int OFFSET_W   = 14;
  localparam logic [UNITS_W-1:0] LEAD_UNITS = 3'd2;
  localparam logic [UNITS_W-1:0] GAP_UNITS  = 3'd3;
  localparam logic [UNITS_W-1:0] TAIL_UNITS = 3'd5;

  // Mode word fields: burst length code, burst order, CAS latency, DLL reset
  localparam logic [11:0] MW_BURST4      = 12'h002;
  localparam logic [11:0] MW_INTERLEAVE  = 12'h008;
  localparam logic [11:0] MW_CAS_2P5     = 12'h060;
  localparam logic [11:0] MW_DLL_RESET   = 12'h100;
  localparam logic [11:0] MW_BASE        = MW_BURST4 | MW_INTERLEAVE | MW_CAS_2P5;
  localparam logic [11:0] EMW_DLL_ON     = 12'h000;

  // Step 0..14 -> command
  function automatic cmd_e step_code(input logic [STEP_W-1:0] s);
    cmd_e c;
    if (s >= 4'd5 && s <= 4'd12) c = CMD_AUTO_REFRESH;
    else begin
      case (s)
        4'd0:    c = CMD_NOP;
        4'd1:    c = CMD_PRECHARGE;
        4'd2:    c = CMD_EXT_MODE_SET;
        4'd3:    c = CMD_MODE_SET;
        4'd4:    c = CMD_PRECHARGE;
        4'd13:   c = CMD_MODE_SET;
        4'd14:   c = CMD_NORMAL;
        default: c = CMD_NOP;
      endcase
    end
    return c;
  endfunction

  // Units waited after each step
  function automatic logic [UNITS_W-1:0] step_post_units(input logic [STEP_W-1:0] s);
    return (s == 4'd3 || s == 4'd13) ? '0 : GAP_UNITS;
  endfunction

  function automatic logic [11:0] step_mode_word(input logic [STEP_W-1:0] s);
    logic [11:0] w;
    case (s)
      4'd2:    w = EMW_DLL_ON;
      4'd3:    w = MW_BASE | MW_DLL_RESET;
      4'd13:   w = MW_BASE;
      default: w = 12'h000;
    endcase
    return w;
  endfunction

  // Mode bit 11 -> address bit 13, mode bits 9:0 -> address bits 12:3
  function automatic logic [OFFSET_W-1:0] fold_mode(input logic [11:0] w);
    logic [OFFSET_W-1:0] wx;
    wx = {2'b00, w};
    return ((wx & 14'h0800) << 2) | ((wx & 14'h03FF) << 3);
  endfunction

endpackage

// File: rtl/ddrinit_unit_timer.sv
module ddrinit_unit_timer
  import ddrinit_pkg::*;
#(
  parameter int UNIT_CYCLES = 40000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [UNITS_W-1:0] units_i,
  output logic               expire_o
);
  localparam int CYC_W = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(UNIT_CYCLES - 1);

  logic               active_q;
  logic [UNITS_W-1:0] rem_q;
  logic [CYC_W-1:0]   cyc_q;
  logic               unit_tick;

  assign unit_tick = active_q && (rem_q != '0) && (cyc_q == CYC_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rem_q    <= '0;
      cyc_q    <= '0;
      expire_o <= 1'b0;
    end else if (load_i) begin
      active_q <= 1'b1;
      rem_q    <= units_i;
      cyc_q    <= '0;
      expire_o <= 1'b0;
    end else if (active_q) begin
      if (rem_q == '0) begin
        active_q <= 1'b0;
        expire_o <= 1'b1;
      end else begin
        expire_o <= 1'b0;
        if (unit_tick) begin
          cyc_q <= '0;
          rem_q <= rem_q - 1'b1;
        end else begin
          cyc_q <= cyc_q + 1'b1;
        end
      end
    end else begin
      expire_o <= 1'b0;
    end
  end

  // An expiry only ends a wait that was running
  assert_expire_after_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |-> $past(active_q));

endmodule

// File: rtl/ddrinit_rank_walk.sv
module ddrinit_rank_walk
  import ddrinit_pkg::*;
#(
  parameter int NUM_RANKS  = 4,
  parameter int BOUND_W    = 8,
  parameter int UNIT_SHIFT = 25
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          go_i,
  input  logic [OFFSET_W-1:0]           offset_i,
  input  logic [NUM_RANKS*BOUND_W-1:0]  rank_end_i,
  output logic                          strobe_o,
  output logic [BOUND_W+UNIT_SHIFT-1:0] addr_o,
  output logic                          done_o
);
  localparam int ADDR_W = BOUND_W + UNIT_SHIFT;
  localparam int IDX_W  = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_RANKS - 1);

  function automatic logic rank_hit(input logic [BOUND_W-1:0] e, input logic [BOUND_W-1:0] s);
    return e > s;
  endfunction

  function automatic logic [ADDR_W-1:0] rank_addr(input logic [BOUND_W-1:0] s,
                                                  input logic [OFFSET_W-1:0] off);
    return ({s, {UNIT_SHIFT{1'b0}}}) + ADDR_W'(off);
  endfunction

  logic [BOUND_W-1:0] bound [NUM_RANKS];
  for (genvar g = 0; g < NUM_RANKS; g++) begin : g_unpack
    assign bound[g] = rank_end_i[g*BOUND_W +: BOUND_W];
  end

  logic                active_q;
  logic [IDX_W-1:0]    idx_q;
  logic [BOUND_W-1:0]  run_q;
  logic [OFFSET_W-1:0] off_q;
  logic [BOUND_W-1:0]  cur_end;
  logic                hit;

  assign cur_end = bound[idx_q];
  assign hit     = rank_hit(cur_end, run_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      run_q    <= '0;
      off_q    <= '0;
      strobe_o <= 1'b0;
      addr_o   <= '0;
      done_o   <= 1'b0;
    end else if (go_i) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      run_q    <= '0;
      off_q    <= offset_i;
      strobe_o <= 1'b0;
      done_o   <= 1'b0;
    end else if (active_q) begin
      strobe_o <= hit;
      if (hit) begin
        addr_o <= rank_addr(run_q, off_q);
        run_q  <= cur_end;
      end
      if (idx_q == IDX_LAST) begin
        active_q <= 1'b0;
        done_o   <= 1'b1;
      end else begin
        idx_q  <= idx_q + 1'b1;
        done_o <= 1'b0;
      end
    end else begin
      strobe_o <= 1'b0;
      done_o   <= 1'b0;
    end
  end

  // Strobes only come out of an active walk
  assert_strobe_in_walk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> $past(active_q));

endmodule

// File: rtl/ddr_init_sequencer.sv
module ddr_init_sequencer
  import ddrinit_pkg::*;
#(
  parameter int UNIT_CYCLES = 40000,
  parameter int NUM_RANKS   = 4,
  parameter int BOUND_W     = 8,
  parameter int UNIT_SHIFT  = 25
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic [NUM_RANKS*BOUND_W-1:0]  rank_end_i,
  output logic [2:0]                    cmd_code_o,
  output logic [BOUND_W+UNIT_SHIFT-1:0] cmd_addr_o,
  output logic                          cmd_strobe_o,
  output logic                          init_done_o,
  output logic                          busy_o
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_ISSUE, S_TAIL} state_e;

  state_e              state_q;
  logic [STEP_W-1:0]   step_q;
  cmd_e                code_q;
  logic                done_q;
  logic                busy_q;

  // Internal events brought out for checking
  logic                tmr_load;
  logic [UNITS_W-1:0]  tmr_units;
  logic                tmr_expire;
  logic                walk_go;
  logic                walk_done;
  logic [OFFSET_W-1:0] walk_off;
  cmd_e                step_cmd;
  logic                all_steps_done;

  assign step_cmd       = step_code(step_q);
  assign all_steps_done = (step_q == STEP_W'(NUM_STEPS));
  assign walk_off       = fold_mode(step_mode_word(step_q));

  always_comb begin
    tmr_load  = 1'b0;
    tmr_units = '0;
    walk_go   = 1'b0;
    case (state_q)
      S_IDLE: if (start_i) begin
        tmr_load  = 1'b1;
        tmr_units = LEAD_UNITS;
      end
      S_WAIT: if (tmr_expire) begin
        if (all_steps_done) begin
          tmr_load  = 1'b1;
          tmr_units = TAIL_UNITS;
        end else if (step_cmd == CMD_NORMAL) begin
          tmr_load  = 1'b1;
          tmr_units = step_post_units(step_q);
        end else begin
          walk_go = 1'b1;
        end
      end
      S_ISSUE: if (walk_done) begin
        tmr_load  = 1'b1;
        tmr_units = step_post_units(step_q);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      code_q  <= CMD_NOP;
      done_q  <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_WAIT;
          step_q  <= '0;
          done_q  <= 1'b0;
          busy_q  <= 1'b1;
        end
        S_WAIT: if (tmr_expire) begin
          if (all_steps_done) begin
            done_q  <= 1'b1;
            state_q <= S_TAIL;
          end else begin
            code_q <= step_cmd;
            if (step_cmd == CMD_NORMAL) step_q <= step_q + 1'b1;
            else                        state_q <= S_ISSUE;
          end
        end
        S_ISSUE: if (walk_done) begin
          step_q  <= step_q + 1'b1;
          state_q <= S_WAIT;
        end
        S_TAIL: if (tmr_expire) begin
          busy_q  <= 1'b0;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  ddrinit_unit_timer #(.UNIT_CYCLES(UNIT_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (tmr_load),
    .units_i  (tmr_units),
    .expire_o (tmr_expire)
  );

  ddrinit_rank_walk #(
    .NUM_RANKS  (NUM_RANKS),
    .BOUND_W    (BOUND_W),
    .UNIT_SHIFT (UNIT_SHIFT)
  ) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_i       (walk_go),
    .offset_i   (walk_off),
    .rank_end_i (rank_end_i),
    .strobe_o   (cmd_strobe_o),
    .addr_o     (cmd_addr_o),
    .done_o     (walk_done)
  );

  assign cmd_code_o  = code_q;
  assign init_done_o = done_q;
  assign busy_o      = busy_q;

  assert_no_strobe_normal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe_o |-> (cmd_code_o != CMD_NORMAL));

  assert_code_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe_o && $past(cmd_strobe_o)) |-> $stable(cmd_code_o));

  assert_done_under_normal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done_o) |-> (cmd_code_o == CMD_NORMAL));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !cmd_strobe_o);

endmodule

// File: tb/test_ddr_init_sequencer.sv
module test_ddr_init_sequencer;
  localparam int U      = 8;
  localparam int NR     = 4;
  localparam int AW     = 33;
  localparam int MAXEXP = 14 * NR;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [NR*8-1:0] bounds = '0;
  logic [2:0]    code;
  logic [AW-1:0] addr;
  logic          strobe, done, busy;

  always #2.5 clk = ~clk;

  ddr_init_sequencer #(.UNIT_CYCLES(U), .NUM_RANKS(NR), .BOUND_W(8), .UNIT_SHIFT(25)) i_ddr_init_sequencer (
    .clk(clk), .rst_n(rst_n), .start_i(start), .rank_end_i(bounds),
    .cmd_code_o(code), .cmd_addr_o(addr), .cmd_strobe_o(strobe),
    .init_done_o(done), .busy_o(busy));

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  logic [2:0]    exp_code [MAXEXP];
  logic [AW-1:0] exp_addr [MAXEXP];
  int            exp_step [MAXEXP];
  int n_exp = 0, n_seen = 0, start_cyc = 0, last_strobe_cyc = 0, done_cyc = 0;
  bit prev_done = 0, prev_busy = 0, monitor_on = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] ref_code(input int s);
    if (s == 0) return 3'd1;
    if (s == 1 || s == 4) return 3'd2;
    if (s == 2) return 3'd4;
    if (s == 3 || s == 13) return 3'd3;
    if (s == 14) return 3'd7;
    return 3'd6;
  endfunction

  function automatic int ref_post(input int s);
    return (ref_code(s) == 3'd3) ? 0 : 3;
  endfunction

  function automatic longint ref_offset(input int s);
    int w;
    w = 0;
    if (s == 3)  w = 2 + 8 + 'h60 + 'h100;
    if (s == 13) w = 2 + 8 + 'h60;
    return (((w >> 11) & 1) * 8192) + ((w % 1024) * 8);
  endfunction

  task automatic build_expected();
    n_exp = 0;
    for (int s = 0; s < 14; s++) begin
      int run;
      run = 0;
      for (int r = 0; r < NR; r++) begin
        int e;
        e = int'(bounds[r*8 +: 8]);
        if (e > run) begin
          exp_code[n_exp] = ref_code(s);
          exp_addr[n_exp] = AW'(longint'(run) * 33554432 + ref_offset(s));
          exp_step[n_exp] = s;
          run = e;
          n_exp++;
        end
      end
    end
  endtask

  always @(negedge clk) begin
    if (monitor_on) begin
      if (strobe) begin
        if (n_seen < n_exp) begin
          chk(code == exp_code[n_seen], "R1/R2", "strobe command code", code, exp_code[n_seen]);
          chk(addr == exp_addr[n_seen], "R4/R5", "strobe address", addr, exp_addr[n_seen]);
          if (n_seen == 0)
            chk(cyc - start_cyc >= 2*U, "R3", "lead wait before NOP", cyc - start_cyc, 2*U);
          else if (exp_step[n_seen] != exp_step[n_seen-1]) begin
            int p, g;
            p = ref_post(exp_step[n_seen-1]);
            g = cyc - last_strobe_cyc;
            chk(g >= p*U + 1 && g <= p*U + NR + 4, "R3", "gap between commands", g, p*U);
          end
        end else begin
          chk(1'b0, "R5", "unexpected extra strobe", n_seen, n_exp);
        end
        chk(code != 3'd7, "R6", "strobe under normal code", code, 0);
        last_strobe_cyc = cyc;
        n_seen++;
      end
      if (done && !prev_done) begin
        done_cyc = cyc;
        if (n_exp > 0)
          chk(cyc - last_strobe_cyc >= 3*U + 1 && cyc - last_strobe_cyc <= 3*U + NR + 6,
              "R7", "wait before init_done", cyc - last_strobe_cyc, 3*U);
      end
      if (!busy && prev_busy)
        chk(cyc - done_cyc >= 5*U && cyc - done_cyc <= 5*U + 4, "R7", "tail wait", cyc - done_cyc, 5*U);
    end
    prev_done = done;
    prev_busy = busy;
  end

  task automatic run_case(input logic [NR*8-1:0] b, input bit poke_mid, input bit after_first);
    @(negedge clk);
    bounds = b;
    build_expected();
    n_seen = 0;
    start = 1'b1;
    start_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
    if (after_first)
      chk(done == 1'b0 && busy == 1'b1, "R8", "restart clears init_done", {done, busy}, 2'b01);
    if (poke_mid) begin
      repeat (10*U) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    chk(n_seen == n_exp, n_exp == 0 ? "R10" : "R2", "strobe count", n_seen, n_exp);
    chk(done == 1'b1, "R7", "init_done after sequence", done, 1);
    chk(code == 3'd7, "R1", "final code is normal", code, 7);
    repeat (3) @(negedge clk);
    chk(done == 1'b1 && !strobe, "R8", "idle holds done, no strobes", {done, strobe}, 2'b10);
  endtask

  initial begin
    void'($urandom(32'h5EED_2024));
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && strobe == 0 && code == 3'd1, "R9", "reset state",
        {busy, done, strobe, code}, 6'b000001);
    rst_n = 1'b1;
    monitor_on = 1'b1;
    run_case({8'd64, 8'd48, 8'd32, 8'd16}, 1'b0, 1'b0);
    run_case({8'd40, 8'd60, 8'd30, 8'd50}, 1'b1, 1'b1);
    run_case({8'd20, 8'd20, 8'd10, 8'd10}, 1'b0, 1'b1);
    run_case({8'd255, 8'd255, 8'd255, 8'd1}, 1'b0, 1'b1);
    run_case({8'd0, 8'd0, 8'd0, 8'd0}, 1'b0, 1'b1);
    for (int k = 0; k < 6; k++) begin
      logic [NR*8-1:0] rb;
      rb = $urandom;
      if (k == 2) rb = rb & 32'h0F0F_0F0F;
      run_case(rb, k[0], 1'b1);
    end
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule